// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This peripheral gives each hart of a small multi-hart processor cluster a machine timer interrupt and a machine software interrupt. A single 64-bit time counter, shared by all harts, advances by one on every clock cycle in which the timebase tick-enable input is high. Each hart owns a 64-bit compare value. Its timer interrupt line is a level that stays high as long as the compare value is at or below the current time. Each hart also owns one software interrupt bit, which any bus master can set or clear. Harts use this bit to signal one another.

All state is reached through a 32-bit register bus. The bus accepts one read or one write per cycle and returns read data one cycle after a read request. The unit has three address regions, each starting at a base set by a parameter:
- one word per hart for the software interrupt bits;
- one 8-byte slot per hart for the compare values, with the low word first and the high word second;
- two words for the time counter, low word then high word.

A 64-bit value is therefore reached as two 32-bit halves. The two halves of the time counter are not sampled together. Software that needs a consistent 64-bit time reads the high word, then the low word, then the high word again, and retries if the high word changed.

Top module: `core_timer_swint`

## Requirements
- R1: After a synchronous active-low reset:
  - the time counter reads 0;
  - every compare half reads 0;
  - every software interrupt bit is 0;
  - every timer interrupt line is 1, because a compare value of 0 is not greater than a time of 0.
- R2: The time counter increases by exactly one on each clock edge where `tick_en` is high and holds otherwise. Its low word reads at `TIME_BASE` and its high word at `TIME_BASE + 4`.
- R3: A read request yields `rsp_valid` high in exactly the following cycle, with the data in `rsp_rdata`. A write request, or no request, yields `rsp_valid` low in the following cycle.
- R4: A write to hart h's software interrupt word, at `SWI_BASE + 4*h`, sets `msip[h]` if the data is nonzero and clears it if the data is zero. Reading that word returns 1 when the bit is set and 0 when it is clear.
- R5: A write to offset 0 of hart h's compare slot, at `CMP_BASE + 8*h`, replaces bits 31:0 and keeps bits 63:32. A write to offset 4 replaces bits 63:32 and keeps bits 31:0. Each half reads back at its own offset.
- R6: `mtip[h]` is high exactly when hart h's compare value is less than or equal to the time counter, compared as unsigned 64-bit numbers.
  - The line is updated on the same edge as a compare write or a tick.
  - Writing a compare value that is already reached raises the line at once.
  - Writing a value greater than the time lowers it.
- R7: The following accesses have no effect on any state, and reads of them return 0:
  - offsets outside all three regions;
  - offsets inside a region but not at a legal word (a software interrupt word not 4-byte aligned, or a compare slot offset other than 0 or 4);
  - writes to the time counter words, which are ignored.
- R8: A write reaches only the hart whose index the address decodes to. The software interrupt index is (address − `SWI_BASE`) >> 2 and the compare index is (address − `CMP_BASE`) >> 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase tick; the time counter advances on each edge where this is high |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the 32-bit access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| mtip | output | NUM_HARTS | Machine timer interrupt, one level per hart |
| msip | output | NUM_HARTS | Machine software interrupt, one level per hart |

## Verification
The embedded properties cover four behaviours on every cycle:
- the timer line of each hart equals the comparison of its stored compare value with the time counter;
- the time counter steps by one on a tick and holds otherwise;
- a half write of a compare register leaves the other half unchanged;
- a read request is answered in the next cycle, and at most one hart's register is written per request.

Only the directed scenarios can show the following:
- the address map and the per-hart decode, including the isolation of one hart from another;
- read data that returns 0 and state that stays untouched for unmapped or misaligned offsets;
- writes to the time words being ignored;
- the exact tick on which a future compare value is reached.

// File: rtl/ctsw_pkg.sv
`timescale 1ns/1ps
// ctsw_pkg: shared widths and value types for the core-local timer unit.
// Assumes a 32-bit register bus and a 64-bit timebase.
package ctsw_pkg;
    localparam int WORD_W = 32;
    localparam int TIME_W = 64;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TIME_W-1:0] tval_t;
endpackage

// File: rtl/ctsw_timebase.sv
`timescale 1ns/1ps
// ctsw_timebase: free-running 64-bit time counter shared by all harts.
// It advances by one on each edge where tick_en is high.
// Besides the registered value it exports the next-cycle value, so that the
// per-hart comparators can update on the same edge as the counter.
// Assumes tick_en is already synchronous to clk.
module ctsw_timebase
    import ctsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_en,
    output tval_t time_q,
    output tval_t time_d
);

    // Next value of the counter.
    always_comb time_d = tick_en ? time_q + tval_t'(1) : time_q;

    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end

    // R2: a tick moves the time up by exactly one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> time_q == $past(time_q) + tval_t'(1));

    // R2: without a tick the time holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_q));

endmodule

// File: rtl/ctsw_hart_slot.sv
`timescale 1ns/1ps
// ctsw_hart_slot: per-hart state.
// Holds a 64-bit compare register written in 32-bit halves, the software
// interrupt bit, and the registered timer interrupt level.
// The level is computed from next-cycle compare and time values, so it
// always matches the current registers.
// Assumes at most one write strobe is high per cycle.
module ctsw_hart_slot
    import ctsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  swi_we,
    input  logic  lo_we,
    input  logic  hi_we,
    input  word_t wdata,
    input  tval_t time_q,
    input  tval_t time_d,
    output tval_t cmp_q,
    output logic  msip_q,
    output logic  mtip_q
);

    tval_t cmp_d;

    // Merge a half-word write with the half that is kept.
    always_comb begin
        cmp_d = cmp_q;
        if (lo_we)      cmp_d = {cmp_q[TIME_W-1:WORD_W], wdata};
        else if (hi_we) cmp_d = {wdata, cmp_q[WORD_W-1:0]};
    end

    // Compare register, software bit and timer level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            msip_q <= 1'b0;
            mtip_q <= 1'b1;
        end else begin
            cmp_q  <= cmp_d;
            mtip_q <= (cmp_d <= time_d);
            if (swi_we) msip_q <= |wdata;
        end
    end

    // R6: the timer level always reflects the current compare and time.
    a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
        mtip_q == (cmp_q <= time_q));

    // R5: a low-half write keeps the high half.
    a_r5_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> cmp_q[TIME_W-1:WORD_W] == $past(cmp_q[TIME_W-1:WORD_W]));

    // R5: a high-half write keeps the low half.
    a_r5_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> cmp_q[WORD_W-1:0] == $past(cmp_q[WORD_W-1:0]));

    // R4: a software word write sets or clears the bit from the data.
    a_r4_swi: assert property (@(posedge clk) disable iff (!rst_n)
        swi_we |=> msip_q == $past(|wdata));

endmodule

// File: rtl/ctsw_bus_decode.sv
`timescale 1ns/1ps
// ctsw_bus_decode: address decode and read path for the register bus.
// Produces one-hot write strobes per hart and a registered read response
// one cycle after each read request.
// Assumes the three regions do not overlap and that every access is 32 bits.
module ctsw_bus_decode
    import ctsw_pkg::*;
#(
    parameter int          NUM_HARTS = 2,
    parameter logic [31:0] SWI_BASE  = 32'h0000_0000,
    parameter logic [31:0] CMP_BASE  = 32'h0000_4000,
    parameter logic [31:0] TIME_BASE = 32'h0000_BFF8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic                             req_write,
    input  logic [31:0]                      req_addr,
    input  logic [NUM_HARTS-1:0]             msip,
    input  logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_all,
    input  tval_t                            time_q,
    output logic [NUM_HARTS-1:0]             swi_we,
    output logic [NUM_HARTS-1:0]             lo_we,
    output logic [NUM_HARTS-1:0]             hi_we,
    output logic                             rsp_valid,
    output word_t                            rsp_rdata
);

    localparam int          IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam logic [31:0] SWI_SPAN = 32'(NUM_HARTS * 4);
    localparam logic [31:0] CMP_SPAN = 32'(NUM_HARTS * 8);

    logic [31:0]      swi_off, cmp_off;
    logic             swi_hit, cmp_hit, swi_ok, lo_ok, hi_ok;
    logic [IDX_W-1:0] swi_idx, cmp_idx;
    logic             wr_req, rd_req;
    word_t            rd_next;

    // Region hits, hart indices and legal word positions.
    always_comb begin
        swi_off = req_addr - SWI_BASE;
        cmp_off = req_addr - CMP_BASE;
        swi_hit = (req_addr >= SWI_BASE) && (swi_off < SWI_SPAN);
        cmp_hit = (req_addr >= CMP_BASE) && (cmp_off < CMP_SPAN);
        swi_idx = IDX_W'(swi_off >> 2);
        cmp_idx = IDX_W'(cmp_off >> 3);
        swi_ok  = swi_hit && (swi_off[1:0] == 2'b00);
        lo_ok   = cmp_hit && (cmp_off[2:0] == 3'd0);
        hi_ok   = cmp_hit && (cmp_off[2:0] == 3'd4);
        wr_req  = req_valid && req_write;
        rd_req  = req_valid && !req_write;
    end

    // One set of write strobes per hart.
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_strobe
        assign swi_we[h] = wr_req && swi_ok && (swi_idx == IDX_W'(h));
        assign lo_we[h]  = wr_req && lo_ok  && (cmp_idx == IDX_W'(h));
        assign hi_we[h]  = wr_req && hi_ok  && (cmp_idx == IDX_W'(h));
    end

    // Read data selection; anything not decoded reads as zero.
    always_comb begin
        rd_next = '0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (swi_ok && swi_idx == IDX_W'(h)) rd_next = word_t'(msip[h]);
            if (lo_ok  && cmp_idx == IDX_W'(h)) rd_next = cmp_all[h][WORD_W-1:0];
            if (hi_ok  && cmp_idx == IDX_W'(h)) rd_next = cmp_all[h][TIME_W-1:WORD_W];
        end
        if (req_addr == TIME_BASE)         rd_next = time_q[WORD_W-1:0];
        if (req_addr == TIME_BASE + 32'd4) rd_next = time_q[TIME_W-1:WORD_W];
    end

    // Registered read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_next;
        end
    end

    // R3: a read request is answered in the next cycle.
    a_r3_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R3: no response without a read request.
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R8: a request writes at most one register of one hart.
    a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({swi_we, lo_we, hi_we}));

endmodule

// File: rtl/core_timer_swint.sv
`timescale 1ns/1ps
// core_timer_swint: core-local timer and software interrupt unit.
// Contains a shared 64-bit timebase, one compare register and one software
// interrupt bit per hart, and a level timer interrupt per hart that is high
// while compare <= time.
// Assumes a single clock domain and 32-bit little-endian accesses.
module core_timer_swint
    import ctsw_pkg::*;
#(
    parameter int          NUM_HARTS = 2,
    parameter logic [31:0] SWI_BASE  = 32'h0000_0000,
    parameter logic [31:0] CMP_BASE  = 32'h0000_4000,
    parameter logic [31:0] TIME_BASE = 32'h0000_BFF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [31:0]          req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_HARTS-1:0] mtip,
    output logic [NUM_HARTS-1:0] msip
);

    tval_t                            time_q, time_d;
    logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_all;
    logic [NUM_HARTS-1:0]             swi_we, lo_we, hi_we;

    ctsw_timebase u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .time_q  (time_q),
        .time_d  (time_d)
    );

    ctsw_bus_decode #(
        .NUM_HARTS (NUM_HARTS),
        .SWI_BASE  (SWI_BASE),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .msip      (msip),
        .cmp_all   (cmp_all),
        .time_q    (time_q),
        .swi_we    (swi_we),
        .lo_we     (lo_we),
        .hi_we     (hi_we),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // One state slot per hart.
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        ctsw_hart_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .swi_we (swi_we[h]),
            .lo_we  (lo_we[h]),
            .hi_we  (hi_we[h]),
            .wdata  (req_wdata),
            .time_q (time_q),
            .time_d (time_d),
            .cmp_q  (cmp_all[h]),
            .msip_q (msip[h]),
            .mtip_q (mtip[h])
        );
    end

endmodule

// File: tb/core_timer_swint_test.sv
`timescale 1ns/1ps
// core_timer_swint_test: directed scenarios, one task each, self-checking.
module core_timer_swint_test;

    localparam int          NH = 2;
    localparam logic [31:0] SB = 32'h0000_0000;
    localparam logic [31:0] CB = 32'h0000_4000;
    localparam logic [31:0] TB = 32'h0000_BFF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NH-1:0] mtip, msip;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] exp_time = 64'd0;

    core_timer_swint #(.NUM_HARTS(NH), .SWI_BASE(SB), .CMP_BASE(CB), .TIME_BASE(TB)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mtip(mtip), .msip(msip)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_valid ? rsp_rdata : 32'hDEAD_0000;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_time += 64'(n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 mtip after reset", 64'(mtip), 64'(2'b11));
        chk("R1 msip after reset", 64'(msip), 64'd0);
        rd(TB, d);        chk("R1 time lo", 64'(d), 64'd0);
        rd(TB + 4, d);    chk("R1 time hi", 64'(d), 64'd0);
        rd(CB + 12, d);   chk("R1 cmp1 hi", 64'(d), 64'd0);
    endtask

    task automatic t_rsp_timing();
        logic [31:0] d;
        rd(SB, d);
        chk("R3 valid after read", 64'(d != 32'hDEAD_0000), 64'd1);
        @(negedge clk);
        chk("R3 valid drops", 64'(rsp_valid), 64'd0);
        wr(CB + 8, 32'd0);
        chk("R3 no valid after write", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_time_count();
        logic [31:0] d;
        tick(5);
        rd(TB, d);     chk("R2 time after 5 ticks", 64'(d), exp_time[31:0]);
        tick(1);
        rd(TB, d);     chk("R2 time after one tick", 64'(d), exp_time[31:0]);
        rd(TB + 4, d); chk("R2 time hi", 64'(d), exp_time[63:32]);
    endtask

    task automatic t_time_write_ignored();
        logic [31:0] d;
        wr(TB, 32'hFFFF_0000);
        wr(TB + 4, 32'h1234_5678);
        rd(TB, d);     chk("R7 time lo write ignored", 64'(d), exp_time[31:0]);
        rd(TB + 4, d); chk("R7 time hi write ignored", 64'(d), exp_time[63:32]);
    endtask

    task automatic t_swi();
        logic [31:0] d;
        wr(SB, 32'h0000_0100);
        chk("R4 set on nonzero", 64'(msip), 64'(2'b01));
        rd(SB, d);     chk("R4 read set", 64'(d), 64'd1);
        wr(SB + 4, 32'h8000_0000);
        chk("R8 hart1 set only", 64'(msip), 64'(2'b11));
        wr(SB, 32'd0);
        chk("R4 clear on zero", 64'(msip), 64'(2'b10));
        rd(SB, d);     chk("R4 read clear", 64'(d), 64'd0);
        rd(SB + 4, d); chk("R4 read hart1", 64'(d), 64'd1);
        wr(SB + 4, 32'd0);
    endtask

    task automatic t_cmp_halves();
        logic [31:0] d;
        wr(CB + 8, 32'hAAAA_5555);
        wr(CB + 12, 32'h1357_9BDF);
        wr(CB + 8, 32'h0F0F_F0F0);
        rd(CB + 8, d);  chk("R5 cmp1 lo", 64'(d), 64'h0F0F_F0F0);
        rd(CB + 12, d); chk("R5 cmp1 hi kept", 64'(d), 64'h1357_9BDF);
        wr(CB + 12, 32'h2468_ACE0);
        rd(CB + 8, d);  chk("R5 cmp1 lo kept", 64'(d), 64'h0F0F_F0F0);
        rd(CB, d);      chk("R8 cmp0 lo untouched", 64'(d), 64'd0);
        rd(CB + 4, d);  chk("R8 cmp0 hi untouched", 64'(d), 64'd0);
        chk("R6 hart1 future", 64'(mtip[1]), 64'd0);
        chk("R8 hart0 still due", 64'(mtip[0]), 64'd1);
    endtask

    task automatic t_timer_level();
        wr(CB, exp_time[31:0] + 32'd3);
        chk("R6 future lowers", 64'(mtip[0]), 64'd0);
        tick(2);
        chk("R6 not yet reached", 64'(mtip[0]), 64'd0);
        tick(1);
        chk("R6 reached on equal", 64'(mtip[0]), 64'd1);
        tick(2);
        chk("R6 stays after pass", 64'(mtip[0]), 64'd1);
        wr(CB, exp_time[31:0] + 32'd100);
        chk("R6 new future lowers", 64'(mtip[0]), 64'd0);
        wr(CB, 32'd0);
        chk("R6 past raises at once", 64'(mtip[0]), 64'd1);
        wr(CB + 4, 32'd1);
        chk("R6 high half future", 64'(mtip[0]), 64'd0);
        wr(CB + 4, 32'd0);
        chk("R6 high half cleared", 64'(mtip[0]), 64'd1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(SB + 8, 32'd1);
        chk("R7 past swi region no set", 64'(msip), 64'd0);
        rd(SB + 8, d);   chk("R7 unmapped reads 0", 64'(d), 64'd0);
        wr(SB + 1, 32'd1);
        chk("R7 misaligned swi no set", 64'(msip), 64'd0);
        wr(CB + 2, 32'hFFFF_FFFF);
        rd(CB, d);       chk("R7 misaligned cmp no write", 64'(d), 64'd0);
        rd(CB + 2, d);   chk("R7 misaligned read 0", 64'(d), 64'd0);
        wr(CB + 16, 32'hFFFF_FFFF);
        rd(CB + 16, d);  chk("R7 past cmp region 0", 64'(d), 64'd0);
        rd(TB - 8, d);   chk("R7 below time 0", 64'(d), 64'd0);
        chk("R7 timer lines unchanged", 64'(mtip), 64'(2'b01));
    endtask

    initial begin
        #(64'd200000 * 64'd10);
        n_chk++; n_fail++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rsp_timing();
        t_time_count();
        t_time_write_ignored();
        t_swi();
        t_cmp_halves();
        t_timer_level();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule